// File: doc/BRIEF.md
# Two-Channel PCM Sample Player

This block is an expansion audio engine with two independent sample channels. Each channel fetches 8-bit unsigned linear samples from memory one byte at a time. It starts at a programmed absolute address and moves forward until it reads the stop byte 0xFF. That byte is never played; on reading it the channel switches itself off. Each channel scales its current sample by its own 8-bit volume, and the two scaled levels are summed into a 9-bit unsigned output.

The CPU programs the block through a byte-wide write port that decodes 16-bit register addresses. It selects a channel by writing that channel's volume. It then writes the selected channel's start address in three parts. Start addresses are aligned to 64-byte blocks. A shared fetch timer paces both channels, and its period comes from a 4-bit rate index in the low bits of the delta-modulation rate register, which this block only observes.

Byte reads leave through a valid/ready request port, and one read is outstanding at a time. The request holds its valid and its address until ready is seen high at a clock edge. The response is a single-cycle valid pulse carrying the byte and may arrive any number of cycles later. The block cannot back-pressure the response, and a new request is issued only after the pending response has returned.

Top module: `pcm_duo`

## Requirements
- R1: After reset, `chan_status` is 0, `mix_out` is 0 and `mem_req_valid` is low.
- R2: A write to 0x4031 sets channel 0's volume and selects channel 0. A write to 0x4032 sets channel 1's volume and selects channel 1. Later address writes go to the selected channel.
- R3: The start address is assembled from three writes. 0x4012 data[7:0] sets address bits 13:6, 0x4035 data[6:0] sets bits 20:14, and 0x4036 data[7:0] sets bits 28:21. Bits 5:0 are zero. A playing channel reads consecutive byte addresses starting from its start address.
- R4: A write to 0x4033 sets the expansion enable from data bit 7, the channel 0 enable from bit 4 and the channel 1 enable from bit 3. Enabling an idle channel loads its read address from its start address and begins playback.
- R5: While a channel plays, it issues one read per fetch period. The period is a number of clock cycles chosen by bits 3:0 of a write to 0x4010 from the table 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 (index 0 to 15). The write to 0x4010 is not claimed.
- R6: Each channel's level is (sample × volume) >> 8. `mix_out` is the 9-bit sum of the two levels.
- R7: A 0xFF byte is not played. The channel's level drops to 0, its status bit clears and its enable bit clears.
- R8: Writes to 0x4012, 0x4035 and 0x4036 are ignored while expansion is disabled or while the selected channel is playing.
- R9: `wr_claim` is high for writes to 0x4031, 0x4032, 0x4033, 0x4035 and 0x4036. It is high for 0x4012 only while expansion is enabled, and low for every other address.
- R10: When both channels need a byte in the same cycle, channel 0's read is issued first.
- R11: `mem_req_valid` stays high with a stable `mem_req_addr` until ready is seen. No new request is issued while a response is outstanding.
- R12: `chan_status` bit 0 is high while channel 0 plays and bit 1 is high while channel 1 plays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| wr_claim | output | 1 | The current write targets a register of this block |
| chan_status | output | 2 | Playing flags: bit 0 channel 0, bit 1 channel 1 |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 29 | Absolute byte address of the request |
| mem_rsp_valid | input | 1 | One-cycle pulse: read data returned |
| mem_rsp_data | input | 8 | Returned byte |
| mix_out | output | 9 | Sum of the two scaled channel levels |

## Verification
A channel whose read pointer is wrong shows up at the next fetch as a wrong `mem_req_addr`, at most one fetch period later. The bench logs every accepted address and compares the log against the expected sequence. An enable bit left stale by the stop byte shows up on `chan_status` two cycles after the 0xFF response. It is also caught later, because a start-address write that should be accepted is rejected, or one that should be rejected is accepted. The next enable then fetches from the wrong base. A wrong rate index or timer reload changes the spacing between logged request cycles, and that spacing is checked exactly.

// File: rtl/pcm_duo_pkg.sv
package pcm_duo_pkg;
  localparam int ADDR_W    = 29;
  localparam int BLK_LSB   = 6;
  localparam logic [7:0] STOP_CODE = 8'hFF;

  localparam logic [15:0] A_RATE = 16'h4010;
  localparam logic [15:0] A_LO   = 16'h4012;
  localparam logic [15:0] A_VOL0 = 16'h4031;
  localparam logic [15:0] A_VOL1 = 16'h4032;
  localparam logic [15:0] A_CTRL = 16'h4033;
  localparam logic [15:0] A_MID  = 16'h4035;
  localparam logic [15:0] A_HI   = 16'h4036;

  typedef enum logic [1:0] {AR_IDLE, AR_ASK, AR_WAIT} arb_st_e;

  function automatic logic [8:0] rate_period(input logic [3:0] idx);
    case (idx)
      4'd0:  return 9'd428;
      4'd1:  return 9'd380;
      4'd2:  return 9'd340;
      4'd3:  return 9'd320;
      4'd4:  return 9'd286;
      4'd5:  return 9'd254;
      4'd6:  return 9'd226;
      4'd7:  return 9'd214;
      4'd8:  return 9'd190;
      4'd9:  return 9'd160;
      4'd10: return 9'd142;
      4'd11: return 9'd128;
      4'd12: return 9'd106;
      4'd13: return 9'd84;
      4'd14: return 9'd72;
      default: return 9'd54;
    endcase
  endfunction
endpackage

// File: rtl/pcm_duo_regs.sv
module pcm_duo_regs
  import pcm_duo_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [15:0]    wr_addr,
  input  logic [3:0]     rate_d,
  input  logic [2:0]     ctl_d,
  input  logic [NCH-1:0] busy,
  output logic           wr_claim,
  output logic           tick,
  output logic [NCH-1:0] vol_we,
  output logic [NCH-1:0] lo_we,
  output logic [NCH-1:0] mid_we,
  output logic [NCH-1:0] hi_we,
  output logic           en_we,
  output logic [NCH-1:0] en_d
);
  localparam int CW = 9;

  logic          sel_q;
  logic          exp_q;
  logic [3:0]    rate_q;
  logic [CW-1:0] cnt_q;
  logic hit_rate, hit_lo, hit_v0, hit_v1, hit_ctl, hit_mid, hit_hi, addr_ok;

  assign hit_rate = wr_en && (wr_addr == A_RATE);
  assign hit_lo   = wr_en && (wr_addr == A_LO);
  assign hit_v0   = wr_en && (wr_addr == A_VOL0);
  assign hit_v1   = wr_en && (wr_addr == A_VOL1);
  assign hit_ctl  = wr_en && (wr_addr == A_CTRL);
  assign hit_mid  = wr_en && (wr_addr == A_MID);
  assign hit_hi   = wr_en && (wr_addr == A_HI);

  assign wr_claim = hit_v0 || hit_v1 || hit_ctl || hit_mid || hit_hi || (hit_lo && exp_q);
  assign addr_ok  = exp_q && !busy[sel_q];

  assign vol_we = {hit_v1, hit_v0};
  assign en_we  = hit_ctl;
  assign en_d   = {ctl_d[0], ctl_d[1]};

  for (genvar k = 0; k < NCH; k++) begin : g_we
    assign lo_we[k]  = hit_lo  && addr_ok && (sel_q == k[0]);
    assign mid_we[k] = hit_mid && addr_ok && (sel_q == k[0]);
    assign hi_we[k]  = hit_hi  && addr_ok && (sel_q == k[0]);
  end

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      exp_q  <= 1'b0;
      rate_q <= 4'd0;
      cnt_q  <= rate_period(4'd0) - 9'd1;
    end else begin
      if (hit_v0) sel_q <= 1'b0;
      if (hit_v1) sel_q <= 1'b1;
      if (hit_ctl) exp_q <= ctl_d[2];
      if (hit_rate) rate_q <= rate_d;
      if (tick) cnt_q <= rate_period(rate_q) - 9'd1;
      else      cnt_q <= cnt_q - 9'd1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R5
  AST_LOCK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && busy[sel_q]) |-> !lo_we[sel_q]); // R8
endmodule

// File: rtl/pcm_duo_chan.sv
module pcm_duo_chan
  import pcm_duo_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    wr_data,
  input  logic          vol_we,
  input  logic          lo_we,
  input  logic          mid_we,
  input  logic          hi_we,
  input  logic          en_we,
  input  logic          en_d,
  input  logic          tick,
  input  logic          grant,
  input  logic          rsp_v,
  input  logic [7:0]    rsp_d,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic          playing,
  output logic [7:0]    level
);
  localparam int HI_W = AW - 21;

  logic [7:0]    vol_q, smp_q;
  logic [AW-1:0] start_q, cur_q;
  logic          play_q, pend_q, wait_q;
  logic [15:0]   prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_q   <= '0;
      smp_q   <= '0;
      start_q <= '0;
      cur_q   <= '0;
      play_q  <= 1'b0;
      pend_q  <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      if (vol_we) vol_q <= wr_data;
      if (lo_we)  start_q[13:BLK_LSB] <= wr_data;
      if (mid_we) start_q[20:14] <= wr_data[6:0];
      if (hi_we)  start_q[AW-1:21] <= wr_data[HI_W-1:0];
      if (rsp_v) wait_q <= 1'b0;
      if (grant) begin
        wait_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (tick && play_q) begin
        pend_q <= 1'b1;
      end
      if (en_we && en_d && !play_q) begin
        play_q <= 1'b1;
        cur_q  <= start_q;
        smp_q  <= '0;
        pend_q <= 1'b0;
      end else if (en_we && !en_d) begin
        play_q <= 1'b0;
        smp_q  <= '0;
        pend_q <= 1'b0;
      end else if (rsp_v && play_q) begin
        if (rsp_d == STOP_CODE) begin
          play_q <= 1'b0;
          smp_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          smp_q <= rsp_d;
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

  assign prod     = smp_q * vol_q;
  assign level    = prod[15:8];
  assign req      = pend_q && !wait_q;
  assign req_addr = cur_q;
  assign playing  = play_q;

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_v && play_q && rsp_d == STOP_CODE && !en_we) |=> !play_q); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_v && play_q && rsp_d != STOP_CODE && !en_we) |=> cur_q == AW'($past(cur_q) + 1'b1)); // R3
  AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    play_q |=> $stable(start_q)); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !play_q |-> smp_q == 8'd0); // R7
endmodule

// File: rtl/pcm_duo_arb.sv
module pcm_duo_arb
  import pcm_duo_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req,
  input  logic [AW-1:0] addr0,
  input  logic [AW-1:0] addr1,
  output logic [1:0]    grant,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic [1:0]    rsp_v
);
  arb_st_e       st_q;
  logic          own_q;
  logic [AW-1:0] addr_q;

  assign grant[0] = (st_q == AR_IDLE) && req[0];
  assign grant[1] = (st_q == AR_IDLE) && req[1] && !req[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= AR_IDLE;
      own_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      case (st_q)
        AR_IDLE: if (|req) begin
          addr_q <= req[0] ? addr0 : addr1;
          own_q  <= !req[0];
          st_q   <= AR_ASK;
        end
        AR_ASK:  if (mem_req_ready) st_q <= AR_WAIT;
        AR_WAIT: if (mem_rsp_valid) st_q <= AR_IDLE;
        default: st_q <= AR_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == AR_ASK);
  assign mem_req_addr  = addr_q;
  assign rsp_v[0] = mem_rsp_valid && (st_q == AR_WAIT) && !own_q;
  assign rsp_v[1] = mem_rsp_valid && (st_q == AR_WAIT) && own_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10
  AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R11
endmodule

// File: rtl/pcm_duo.sv
module pcm_duo
  import pcm_duo_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [15:0]   wr_addr,
  input  logic [7:0]    wr_data,
  output logic          wr_claim,
  output logic [1:0]    chan_status,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data,
  output logic [8:0]    mix_out
);
  localparam int NCH = 2;

  logic           tick, en_we;
  logic [NCH-1:0] vol_we, lo_we, mid_we, hi_we, en_d;
  logic [NCH-1:0] busy, req, grant, rsp_v;
  logic [AW-1:0]  ch_addr [NCH];
  logic [7:0]     ch_lvl  [NCH];

  pcm_duo_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rate_d(wr_data[3:0]), .ctl_d({wr_data[7], wr_data[4], wr_data[3]}),
    .busy(busy), .wr_claim(wr_claim), .tick(tick),
    .vol_we(vol_we), .lo_we(lo_we), .mid_we(mid_we), .hi_we(hi_we),
    .en_we(en_we), .en_d(en_d)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pcm_duo_chan #(.AW(AW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
      .vol_we(vol_we[k]), .lo_we(lo_we[k]), .mid_we(mid_we[k]), .hi_we(hi_we[k]),
      .en_we(en_we), .en_d(en_d[k]), .tick(tick), .grant(grant[k]),
      .rsp_v(rsp_v[k]), .rsp_d(mem_rsp_data),
      .req(req[k]), .req_addr(ch_addr[k]), .playing(busy[k]), .level(ch_lvl[k])
    );
  end

  pcm_duo_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .addr0(ch_addr[0]), .addr1(ch_addr[1]),
    .grant(grant), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .rsp_v(rsp_v)
  );

  assign chan_status = busy;
  assign mix_out     = 9'(ch_lvl[0]) + 9'(ch_lvl[1]);
endmodule

// File: tb/sim_pcm_duo.sv
module sim_pcm_duo;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_claim;
  logic [1:0]  chan_status;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [28:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic [8:0]  mix_out;

  pcm_duo u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  int errs = 0, checks = 0;
  int cyc = 0, rsp_cnt = 0, log_n = 0, hold_viol = 0, out_viol = 0;
  bit rdy_mode = 1'b1;
  bit pend = 1'b0, prev_stall = 1'b0;
  int lat = 0;
  logic [28:0] paddr = '0, prev_a = '0;
  logic [28:0] log_a [64];
  int          log_t [64];

  function automatic logic [7:0] mem_byte(input logic [28:0] a);
    if (a[5:0] == 6'd3) return 8'hFF;
    return 8'h40 + 8'(a[5:0]) * 8'h20;
  endfunction

  // memory model, acts at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (mem_req_valid && pend) out_viol++;
    if (prev_stall && (!mem_req_valid || mem_req_addr != prev_a)) hold_viol++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_byte(paddr);
        pend = 1'b0;
        rsp_cnt++;
      end else lat--;
    end
    mem_req_ready = rdy_mode ? (cyc % 3 != 0) : 1'b1;
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_a = mem_req_addr;
    if (mem_req_valid && mem_req_ready) begin
      pend = 1'b1; lat = 1; paddr = mem_req_addr;
      if (log_n < 64) begin log_a[log_n] = mem_req_addr; log_t[log_n] = cyc; end
      log_n++;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp_v);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_rsp(input int n);
    while (rsp_cnt < n) step();
    step(); step();
  endtask

  // {address, data, expected claim}
  localparam logic [24:0] VEC [10] = '{
    {16'h4012, 8'h00, 1'b0},
    {16'h4031, 8'h80, 1'b1},
    {16'h4033, 8'h80, 1'b1},
    {16'h4012, 8'h00, 1'b1},
    {16'h4035, 8'h00, 1'b1},
    {16'h4036, 8'h00, 1'b1},
    {16'h4010, 8'h0F, 1'b0},
    {16'h4014, 8'h00, 1'b0},
    {16'h4032, 8'h40, 1'b1},
    {16'h4000, 8'h00, 1'b0}
  };

  initial begin
    repeat (WDOG) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired (R11 stall?) actual=%0d expected=done", WDOG);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(chan_status == 2'b00, "R1 status", 32'(chan_status), 0);
    chk(mix_out == 9'd0, "R1 mix", 32'(mix_out), 0);
    chk(!mem_req_valid, "R1 req", 32'(mem_req_valid), 0);

    // R9 claim table, also sets volumes (R2), expansion, ch0 start, rate 15
    for (int i = 0; i < 10; i++) begin
      wr_en = 1'b1; wr_addr = VEC[i][24:9]; wr_data = VEC[i][8:1];
      #1;
      chk(wr_claim == VEC[i][0], "R9 claim", 32'(wr_claim), 32'(VEC[i][0]));
      step();
      wr_en = 1'b0;
    end

    // R3 channel 1 start = 0x608040 (ch1 selected by the 0x4032 write, R2)
    wr(16'h4012, 8'h01);
    wr(16'h4035, 8'h02);
    wr(16'h4036, 8'h03);
    wr(16'h4033, 8'h98);
    chk(chan_status == 2'b11, "R12 both playing", 32'(chan_status), 3);

    wait_rsp(2);
    chk(mix_out == 9'h030, "R6 mix first", 32'(mix_out), 32'h30);
    wait_rsp(4);
    chk(mix_out == 9'h048, "R6 mix second", 32'(mix_out), 32'h48);
    wait_rsp(6);
    chk(mix_out == 9'h060, "R6 mix third", 32'(mix_out), 32'h60);
    wait_rsp(8);
    chk(chan_status == 2'b00, "R7 status after stop", 32'(chan_status), 0);
    chk(mix_out == 9'd0, "R7 stop byte not played", 32'(mix_out), 0);
    for (int k = 0; k < 4; k++) begin
      chk(log_a[2*k] == 29'(k), "R10 ch0 first / R3 address", 32'(log_a[2*k]), k);
      chk(log_a[2*k+1] == 29'h608040 + 29'(k), "R3 ch1 address", 32'(log_a[2*k+1]), 32'h608040 + k);
    end
    chk(hold_viol == 0, "R11 valid held under stall", hold_viol, 0);
    chk(out_viol == 0, "R11 single outstanding", out_viol, 0);
    rdy_mode = 1'b0;

    // run A: new start accepted while idle, rejected while playing
    wr(16'h4012, 8'h02);
    wr(16'h4033, 8'h88);
    chk(chan_status == 2'b10, "R12 ch1 only", 32'(chan_status), 2);
    while (log_n < 9) step();
    wr(16'h4012, 8'h05);
    wait_rsp(12);
    chk(chan_status == 2'b00, "R7 ch1 enable cleared", 32'(chan_status), 0);
    for (int k = 0; k < 4; k++)
      chk(log_a[8+k] == 29'h608080 + 29'(k), "R4 start reload", 32'(log_a[8+k]), 32'h608080 + k);
    chk(log_t[9] - log_t[8] == 54, "R5 period index 15", log_t[9] - log_t[8], 54);

    // run B: rate 14, address write ignored with expansion off
    wr(16'h4010, 8'h0E);
    wr(16'h4033, 8'h00);
    wr_en = 1'b1; wr_addr = 16'h4012; wr_data = 8'h07;
    #1;
    chk(wr_claim == 1'b0, "R9 not claimed when off", 32'(wr_claim), 0);
    step();
    wr_en = 1'b0;
    wr(16'h4033, 8'h88);
    wait_rsp(16);
    for (int k = 0; k < 4; k++)
      chk(log_a[12+k] == 29'h608080 + 29'(k), "R8 writes ignored", 32'(log_a[12+k]), 32'h608080 + k);
    chk(log_t[14] - log_t[13] == 72, "R5 period index 14", log_t[14] - log_t[13], 72);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule